// File: doc/BRIEF.md
# Prefix-Extended Unified Register File

This block holds 1024 register words split into a lower bank (addresses 0x000–0x1FF) and an upper bank (0x200–0x3FF). An execution pipeline reads a destination operand and a source operand through 9-bit fields, so a plain instruction reaches only the lower bank. A one-shot prefix placed before an instruction supplies a tenth address bit for the destination, the source, or both. Any ordinary ALU instruction can then work on upper-bank registers as if they were lower-bank registers. Instruction fetch takes a full 10-bit address and reads either bank without a prefix.

Each bank has two read ports and one write port, and reads return the stored value from before any write in the same cycle. The first read port serves the destination operand or a fetch. The second read port serves the source operand. When stream mode is on, the second read port of the upper bank leaves the operand path and serves a streamer address instead. While stream mode is on, an operand access that a prefix steers into the upper bank returns zero, cancels that instruction's write-back and sets a sticky error flag.

The write-back address is taken when the operands are read. A prefix that arrives later cannot move the write.

Top module: `rf_unified`

## Requirements
- R1: After reset, `rd_d`, `rd_s`, `fetch_rdata` and `str_rdata` are zero and `access_err` is low.
- R2: With no prefix pending, an `op_valid` cycle reads lower register `op_d` onto `rd_d` and lower register `op_s` onto `rd_s`. Both values appear in the following cycle.
- R3: A `pfx_valid` cycle loads a pending tenth bit. `pfx_sel[0]` selects the destination field and takes its value from `pfx_bits[0]`. `pfx_sel[1]` selects the source field and takes its value from `pfx_bits[1]`. The two fields are independent, and each pending bit becomes bit 9 of that operand's address at the next `op_valid`.
- R4: Pending prefix bits act on one instruction only. The `op_valid` cycle that uses them clears them to zero.
- R5: A later prefix for the same field replaces the pending bit and does not add to it. A prefix for the other field leaves it unchanged.
- R6: A `fetch_en` cycle without `op_valid` reads the full 10-bit `fetch_addr` from either bank onto `fetch_rdata` in the next cycle. No prefix is needed.
- R7: `wb_en` writes `wb_data` to the 10-bit destination address captured at the most recent `op_valid`, including its prefix bit. Prefixes that arrive after that operand read do not change the target.
- R8: When a write and a read hit the same address in the same cycle, the read returns the data from before the write.
- R9: While `stream_mode` is high, `str_rdata` shows upper register `0x200 + str_addr` one cycle later. While `stream_mode` is low, `str_rdata` is zero. Lower-bank source reads and fetches from either bank keep working in stream mode.
- R10: In an `op_valid` cycle with `stream_mode` high, any operand whose pending tenth bit is 1 reads as zero. That instruction's write-back is cancelled, and `access_err` rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_mode | input | 1 | Hands the upper bank's second read port to the streamer |
| fetch_en | input | 1 | Instruction fetch request |
| fetch_addr | input | 10 | Full fetch address |
| fetch_rdata | output | 32 | Fetched word, one cycle after request |
| pfx_valid | input | 1 | Prefix instruction present |
| pfx_sel | input | 2 | Field select: bit 0 destination, bit 1 source |
| pfx_bits | input | 2 | Tenth-bit values: bit 0 destination, bit 1 source |
| op_valid | input | 1 | Operand read for an ALU instruction |
| op_d | input | 9 | Destination field |
| op_s | input | 9 | Source field |
| rd_d | output | 32 | Destination operand value |
| rd_s | output | 32 | Source operand value |
| wb_en | input | 1 | Write-back strobe |
| wb_data | input | 32 | Write-back result |
| str_addr | input | 9 | Streamer index into the upper bank |
| str_rdata | output | 32 | Streamer read data |
| access_err | output | 1 | Sticky flag for blocked upper operand access |

## Verification
The bench first fills matching indices in both banks with distinct values. It then reads the same 9-bit fields four ways: with no prefix, with a destination prefix, with a source prefix, and with both. A bank-steering error therefore shows up as a wrong value, not as a coincidental match.

Prefix ordering is tested in three ways:
- A prefix is followed by an unprefixed instruction.
- A prefix is overridden by a second prefix for the same field.
- A prefix arrives between an operand read and its write-back.

These separate the one-shot, replacement and write-target rules.

Stream mode is tested by reading the streamer, lower source operands and upper fetches side by side. Blocked upper accesses are checked for a zeroed operand, a write that is lost, and an error flag that stays set.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_DW    = 32;
    localparam int RF_LAW   = 9;
    localparam int RF_AW    = RF_LAW + 1;
    localparam int RF_DEPTH = 1 << RF_LAW;
    localparam int RF_BANKS = 2;

    typedef logic [RF_DW-1:0]  rf_word_t;
    typedef logic [RF_LAW-1:0] rf_idx_t;
    typedef logic [RF_AW-1:0]  rf_addr_t;

    typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;

    typedef struct packed {
        logic    ok;
        bank_e   bank;
        rf_idx_t idx;
    } wb_target_t;

    function automatic rf_addr_t rf_join(input logic hi, input rf_idx_t idx);
        return {hi, idx};
    endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_data,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered reads sample the array before this edge's write lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_data <= '0;
            b_data <= '0;
        end else begin
            if (a_en) a_data <= mem[a_addr];
            if (b_en) b_data <= mem[b_addr];
        end
    end
endmodule

// File: rtl/rf_prefix.sv
module rf_prefix (
    input  logic       clk,
    input  logic       rst,
    input  logic       pfx_valid,
    input  logic [1:0] pfx_sel,
    input  logic [1:0] pfx_bits,
    input  logic       consume,
    output logic       d_hi,
    output logic       s_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_hi <= 1'b0;
            s_hi <= 1'b0;
        end else begin
            if (consume) begin
                d_hi <= 1'b0;
                s_hi <= 1'b0;
            end
            if (pfx_valid && pfx_sel[0]) d_hi <= pfx_bits[0];
            if (pfx_valid && pfx_sel[1]) s_hi <= pfx_bits[1];
        end
    end

    assert_prefix_oneshot_R4: assert property (@(posedge clk) disable iff (rst)
        (consume && !pfx_valid) |=> (!d_hi && !s_hi));

    assert_prefix_replace_R5: assert property (@(posedge clk) disable iff (rst)
        (pfx_valid && pfx_sel[0]) |=> (d_hi == $past(pfx_bits[0])));

    assert_prefix_other_field_R3: assert property (@(posedge clk) disable iff (rst)
        (pfx_valid && pfx_sel == 2'b01 && !consume) |=> $stable(s_hi));
endmodule

// File: rtl/rf_unified.sv
module rf_unified
    import rf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stream_mode,
    input  logic     fetch_en,
    input  rf_addr_t fetch_addr,
    output rf_word_t fetch_rdata,
    input  logic     pfx_valid,
    input  logic [1:0] pfx_sel,
    input  logic [1:0] pfx_bits,
    input  logic     op_valid,
    input  rf_idx_t  op_d,
    input  rf_idx_t  op_s,
    output rf_word_t rd_d,
    output rf_word_t rd_s,
    input  logic     wb_en,
    input  rf_word_t wb_data,
    input  rf_idx_t  str_addr,
    output rf_word_t str_rdata,
    output logic     access_err
);
    logic d_hi, s_hi;
    logic blk_d, blk_s;
    rf_addr_t   d_full;
    wb_target_t wb_q;

    rf_word_t pa_q [RF_BANKS];
    rf_word_t pb_q [RF_BANKS];

    logic sel_a_q, sel_b_q, z_d_q, z_s_q, str_v_q, err_q;

    rf_prefix u_prefix (
        .clk(clk), .rst(rst),
        .pfx_valid(pfx_valid), .pfx_sel(pfx_sel), .pfx_bits(pfx_bits),
        .consume(op_valid),
        .d_hi(d_hi), .s_hi(s_hi)
    );

    assign blk_d  = stream_mode && d_hi;
    assign blk_s  = stream_mode && s_hi;
    assign d_full = rf_join(d_hi, op_d);

    generate
        for (genvar b = 0; b < RF_BANKS; b++) begin : g_bank
            logic    we_b, b_en_b;
            rf_idx_t a_addr_b, b_addr_b;

            assign we_b     = wb_en && wb_q.ok && (wb_q.bank == bank_e'(b));
            assign a_addr_b = op_valid ? op_d : fetch_addr[RF_LAW-1:0];

            if (b == int'(BANK_HI)) begin : g_stream_port
                assign b_addr_b = stream_mode ? str_addr : op_s;
                assign b_en_b   = stream_mode || op_valid;
            end else begin : g_plain_port
                assign b_addr_b = op_s;
                assign b_en_b   = op_valid;
            end

            rf_bank #(.DW(RF_DW), .DEPTH(RF_DEPTH)) u_bank (
                .clk(clk), .rst(rst),
                .we(we_b), .waddr(wb_q.idx), .wdata(wb_data),
                .a_en(op_valid || fetch_en), .a_addr(a_addr_b), .a_data(pa_q[b]),
                .b_en(b_en_b), .b_addr(b_addr_b), .b_data(pb_q[b])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_a_q <= 1'b0;
            sel_b_q <= 1'b0;
            z_d_q   <= 1'b0;
            z_s_q   <= 1'b0;
            str_v_q <= 1'b0;
            err_q   <= 1'b0;
            wb_q    <= '{ok: 1'b0, bank: BANK_LO, idx: '0};
        end else begin
            str_v_q <= stream_mode;
            z_d_q   <= op_valid && blk_d;
            z_s_q   <= op_valid && blk_s;
            if (op_valid) begin
                sel_a_q <= d_hi;
                sel_b_q <= s_hi;
                wb_q    <= '{ok: !(blk_d || blk_s),
                             bank: bank_e'(d_full[RF_AW-1]),
                             idx: d_full[RF_LAW-1:0]};
                if (blk_d || blk_s) err_q <= 1'b1;
            end else if (fetch_en) begin
                sel_a_q <= fetch_addr[RF_AW-1];
            end
        end
    end

    assign fetch_rdata = sel_a_q ? pa_q[BANK_HI] : pa_q[BANK_LO];
    assign rd_d        = z_d_q ? '0 : fetch_rdata;
    assign rd_s        = z_s_q ? '0 : (sel_b_q ? pb_q[BANK_HI] : pb_q[BANK_LO]);
    assign str_rdata   = str_v_q ? pb_q[BANK_HI] : '0;
    assign access_err  = err_q;

    assert_blocked_d_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && stream_mode && d_hi) |=> (rd_d == '0 && access_err));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        access_err |=> access_err);

    assert_stream_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !stream_mode |=> (str_rdata == '0));

    assert_no_write_when_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (blk_d || blk_s)) |=> !(g_bank[0].we_b || g_bank[1].we_b));
endmodule

// File: tb/tb_rf_unified.sv
module tb_rf_unified;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stream_mode = 1'b0;
    logic        fetch_en = 1'b0;
    logic [9:0]  fetch_addr = '0;
    logic [31:0] fetch_rdata;
    logic        pfx_valid = 1'b0;
    logic [1:0]  pfx_sel = '0;
    logic [1:0]  pfx_bits = '0;
    logic        op_valid = 1'b0;
    logic [8:0]  op_d = '0;
    logic [8:0]  op_s = '0;
    logic [31:0] rd_d, rd_s;
    logic        wb_en = 1'b0;
    logic [31:0] wb_data = '0;
    logic [8:0]  str_addr = '0;
    logic [31:0] str_rdata;
    logic        access_err;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rf_unified dut (
        .clk(clk), .rst(rst), .stream_mode(stream_mode),
        .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
        .pfx_valid(pfx_valid), .pfx_sel(pfx_sel), .pfx_bits(pfx_bits),
        .op_valid(op_valid), .op_d(op_d), .op_s(op_s), .rd_d(rd_d), .rd_s(rd_s),
        .wb_en(wb_en), .wb_data(wb_data),
        .str_addr(str_addr), .str_rdata(str_rdata), .access_err(access_err)
    );

    localparam logic [31:0] VA = 32'hA000_0005, VB = 32'hB000_01FF;
    localparam logic [31:0] VC = 32'hC000_0205, VD = 32'hD000_03FF;
    localparam logic [31:0] VF = 32'hF000_0010, VG = 32'h6000_0210;
    localparam logic [31:0] VE = 32'hE000_0E0E, VN = 32'h1234_5678;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_pfx(input logic [1:0] sel, input logic [1:0] bits);
        @(negedge clk); pfx_valid = 1'b1; pfx_sel = sel; pfx_bits = bits;
        @(negedge clk); pfx_valid = 1'b0; pfx_sel = '0; pfx_bits = '0;
    endtask

    task automatic do_op(input logic [8:0] d, input logic [8:0] s);
        @(negedge clk); op_valid = 1'b1; op_d = d; op_s = s;
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic do_wb(input logic [31:0] v);
        @(negedge clk); wb_en = 1'b1; wb_data = v;
        @(negedge clk); wb_en = 1'b0;
    endtask

    task automatic do_fetch(input logic [9:0] a);
        @(negedge clk); fetch_en = 1'b1; fetch_addr = a;
        @(negedge clk); fetch_en = 1'b0;
    endtask

    task automatic write_reg(input logic [9:0] a, input logic [31:0] v);
        if (a[9]) do_pfx(2'b01, 2'b01);
        do_op(a[8:0], 9'd0);
        do_wb(v);
    endtask

    task automatic t_reset;
        chk("R1 rd_d", rd_d, 0);
        chk("R1 rd_s", rd_s, 0);
        chk("R1 fetch", fetch_rdata, 0);
        chk("R1 str", str_rdata, 0);
        chk("R1 err", {31'd0, access_err}, 0);
    endtask

    task automatic t_plain;
        do_op(9'h005, 9'h1FF);
        chk("R2 d lower", rd_d, VA);
        chk("R2 s lower", rd_s, VB);
        do_op(9'h1FF, 9'h005);
        chk("R2 d swapped", rd_d, VB);
        chk("R2 s swapped", rd_s, VA);
    endtask

    task automatic t_prefix;
        do_pfx(2'b01, 2'b01); do_op(9'h005, 9'h005);
        chk("R3 d-prefix d", rd_d, VC); chk("R3 d-prefix s", rd_s, VA);
        do_pfx(2'b10, 2'b10); do_op(9'h005, 9'h1FF);
        chk("R3 s-prefix d", rd_d, VA); chk("R3 s-prefix s", rd_s, VD);
        do_pfx(2'b11, 2'b11); do_op(9'h1FF, 9'h005);
        chk("R3 both d", rd_d, VD); chk("R3 both s", rd_s, VC);
        do_op(9'h005, 9'h1FF);
        chk("R4 after one-shot d", rd_d, VA); chk("R4 after one-shot s", rd_s, VB);
    endtask

    task automatic t_replace;
        do_pfx(2'b01, 2'b01); do_pfx(2'b01, 2'b00); do_op(9'h005, 9'h005);
        chk("R5 replaced d", rd_d, VA);
        do_pfx(2'b01, 2'b01); do_pfx(2'b10, 2'b10); do_op(9'h005, 9'h1FF);
        chk("R5 kept d", rd_d, VC); chk("R5 other s", rd_s, VD);
    endtask

    task automatic t_fetch;
        do_fetch(10'h205); chk("R6 fetch upper", fetch_rdata, VC);
        do_fetch(10'h005); chk("R6 fetch lower", fetch_rdata, VA);
        do_fetch(10'h3FF); chk("R6 fetch top", fetch_rdata, VD);
    endtask

    task automatic t_wb_capture;
        do_op(9'h010, 9'h000);
        do_pfx(2'b01, 2'b01);
        do_wb(VE);
        do_op(9'h010, 9'h010);
        chk("R7 upper untouched", rd_d, VG);
        chk("R7 lower written", rd_s, VE);
    endtask

    task automatic t_rbw;
        do_op(9'h005, 9'h000);
        @(negedge clk); op_valid = 1'b1; op_d = 9'h005; op_s = 9'h005; wb_en = 1'b1; wb_data = VN;
        @(negedge clk); op_valid = 1'b0; wb_en = 1'b0;
        chk("R8 old d", rd_d, VA); chk("R8 old s", rd_s, VA);
        do_op(9'h005, 9'h005);
        chk("R8 new after", rd_d, VN);
    endtask

    task automatic t_stream;
        @(negedge clk); stream_mode = 1'b1; str_addr = 9'h005;
        @(negedge clk); chk("R9 stream read", str_rdata, VC);
        str_addr = 9'h1FF;
        @(negedge clk); chk("R9 stream read top", str_rdata, VD);
        do_op(9'h1FF, 9'h1FF);
        chk("R9 lower s in stream", rd_s, VB);
        chk("R9 no err plain", {31'd0, access_err}, 0);
        do_fetch(10'h205); chk("R9 upper fetch in stream", fetch_rdata, VC);
        do_pfx(2'b01, 2'b01); do_op(9'h005, 9'h1FF);
        chk("R10 blocked d zero", rd_d, 0);
        chk("R10 lower s ok", rd_s, VB);
        chk("R10 err set", {31'd0, access_err}, 1);
        do_wb(32'hDEAD_BEEF);
        do_pfx(2'b10, 2'b10); do_op(9'h1FF, 9'h005);
        chk("R10 blocked s zero", rd_s, 0);
        @(negedge clk); stream_mode = 1'b0;
        @(negedge clk); chk("R9 stream off zero", str_rdata, 0);
        chk("R10 err sticky", {31'd0, access_err}, 1);
        do_pfx(2'b01, 2'b01); do_op(9'h005, 9'h1FF);
        chk("R10 write suppressed", rd_d, VC);
        do_op(9'h005, 9'h1FF);
        chk("R10 lower untouched", rd_d, VN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        write_reg(10'h005, VA); write_reg(10'h1FF, VB);
        write_reg(10'h205, VC); write_reg(10'h3FF, VD);
        write_reg(10'h010, VF); write_reg(10'h210, VG);
        t_plain();
        t_prefix();
        t_replace();
        t_fetch();
        t_wb_capture();
        t_rbw();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule